// File: doc/BRIEF.md
# DMA Channel Command Register File

This block is the host-facing register bank for a configurable number of DMA channels. A simple word-addressed register port, driven by the completer side of the host link, reaches every register. Two read-only capability words report the channel count, the command queue depth and a 2-bit kind code for each channel, so that a driver can configure itself without build-time knowledge.

Each channel owns a small register group. The host first writes a target address into a staging register, then writes a transfer size. The size write enqueues the address and the size together as one command. The channel's control register holds an enable bit, a sticky overflow flag and the current queue level. Downstream arbiters see the head command of every enabled channel and pop it when they accept it. They also pulse a done line for each finished transfer, which steps an 8-bit completion counter. Four of these counters share one 32-bit word, so a poll loop reads only a few addresses.

One global address window is passed through to a user register port with its offset inside the window. The internal registers stay out of reach of user logic. Every read is answered exactly one cycle after its request.

Top module: `dma_chan_regfile`

## Requirements
- R1: Word 0 reads the channel count in bits [7:0] and the queue depth in bits [15:8]. Word 1 reads the 2-bit kind code of channel i at bits [2i+1:2i], with zeros above the last channel. Writes to either word change nothing.
- R2: Channel i's registers sit at word 64+4i (address staging), 65+4i (size, which enqueues) and 66+4i (control). A size write while an address is staged enqueues the pair. Commands leave in first-in first-out order on cmd_addr and cmd_size, and a cmd_pop with cmd_valid high advances to the next command.
- R3: A size write with no address staged since the previous size write is ignored. Every size write clears the staged state.
- R4: A size write to a full queue is dropped, leaves the queue unchanged and sets the overflow flag (control bit 1). The flag stays set until a control write with bit 1 set. A new overflow in the same cycle as a clear leaves the flag set.
- R5: Control bit 0 is the enable, written directly. cmd_valid is high only when the channel is enabled and its queue is non-empty. A pop while disabled is ignored. Control reads return enable in bit 0, overflow in bit 1, address-staged in bit 2 and the queue level in bits [15:8]. The staging register reads back the staged address, and the size register reads zero.
- R6: Each cmd_done cycle steps that channel's 8-bit completion counter, which wraps from 255 to 0. The counter of channel 4k+j reads at word 16+k, bits [8j+7:8j].
- R7: A read request produces rsp_valid for exactly one cycle, in the cycle after the request. Writes produce no response.
- R8: Reads of unmapped words return zero. Writes to unmapped words have no effect.
- R9: An access inside [USER_BASE, USER_BASE+USER_WORDS) raises usr_wr_en or usr_rd_en in the request cycle, with the in-window offset on usr_addr. The read response carries usr_rdata as sampled in the response cycle. Accesses outside the window never raise these strobes.
- R10: After reset all queues are empty, cmd_valid is low, and all control fields and completion counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | DATA_W | Read data |
| usr_wr_en | output | 1 | User window write strobe |
| usr_rd_en | output | 1 | User window read strobe |
| usr_addr | output | USER_AW | Offset inside the user window |
| usr_wdata | output | DATA_W | User write data |
| usr_rdata | input | DATA_W | User read data, one cycle after usr_rd_en |
| cmd_valid | output | NUM_CH | Head command present and channel enabled |
| cmd_addr | output | NUM_CH*DATA_W | Head command address, channel i at [i*DATA_W +: DATA_W] |
| cmd_size | output | NUM_CH*DATA_W | Head command size, same packing |
| cmd_pop | input | NUM_CH | Arbiter accepts the head command |
| cmd_done | input | NUM_CH | Completion pulse per channel |

## Verification
The bench fills one queue past its depth and then checks that the overflow flag sets, that the head command survives, and that a control write without bit 1 does not clear the flag. A design that overwrote the queue or cleared the flag on every control write would fail these checks. It posts a size write with no staged address; a design that enqueued a stale address would show a level of one. It drives 255 completions and then one more on a middle channel to catch a counter that saturates or spills into a neighbouring field, and it reads two completion words to catch wrong packing. User-window reads at both edges, and accesses just outside the window, expose off-by-one window decoding and a response that returns the internal read value instead of the user data.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
   localparam int unsigned CAP_ID_ADR    = 0;
   localparam int unsigned CAP_TYPE_ADR  = 1;
   localparam int unsigned CPL_BASE_ADR  = 16;
   localparam int unsigned CH_BASE_ADR   = 64;
   localparam int unsigned CH_STRIDE     = 4;
   localparam int unsigned CH_OFS_ADDR   = 0;
   localparam int unsigned CH_OFS_SIZE   = 1;
   localparam int unsigned CH_OFS_CTRL   = 2;
   localparam int unsigned CTRL_EN       = 0;
   localparam int unsigned CTRL_OVF      = 1;
   localparam int unsigned CPL_W         = 8;
   localparam int unsigned CPL_PER_WORD  = 4;
   localparam int unsigned MAX_CH        = 16;
   localparam int unsigned REG_SPACE_END = CH_BASE_ADR + CH_STRIDE * MAX_CH;

   function automatic logic [31:0] pack_ctrl(input logic en, input logic ovf,
                                             input logic stg, input logic [7:0] lvl);
      return {16'h0000, lvl, 5'b00000, stg, ovf, en};
   endfunction
endpackage

// File: rtl/dcr_cmd_fifo.sv
module dcr_cmd_fifo #(
   parameter int unsigned WIDTH = 64,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full,
   output logic [CNT_W-1:0] level
);
   generate
      if (DEPTH == 0) begin : g_bad_depth
         $error("dcr_cmd_fifo: DEPTH must be at least 1");
      end else if (DEPTH == 1) begin : g_single
         logic [WIDTH-1:0] hold_q;
         logic             hold_v;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hold_v <= 1'b0;
            end else begin
               hold_v <= (hold_v && !pop) || (push && !hold_v);
            end
         end
         always_ff @(posedge clk) begin
            if (push && !hold_v) hold_q <= din;
         end
         assign dout  = hold_q;
         assign empty = !hold_v;
         assign full  = hold_v;
         assign level = CNT_W'(hold_v);
      end else begin : g_ring
         localparam int unsigned PTR_W = $clog2(DEPTH);
         if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
            $error("dcr_cmd_fifo: DEPTH must be a power of two");
         end
         logic [WIDTH-1:0] mem [DEPTH];
         logic [PTR_W-1:0] wp_q, rp_q;
         logic [CNT_W-1:0] cnt_q;
         logic             do_push, do_pop;

         assign do_push = push && (cnt_q != CNT_W'(DEPTH));
         assign do_pop  = pop && (cnt_q != '0);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wp_q  <= '0;
               rp_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (do_push) wp_q <= wp_q + 1'b1;
               if (do_pop)  rp_q <= rp_q + 1'b1;
               case ({do_push, do_pop})
                  2'b10:   cnt_q <= cnt_q + 1'b1;
                  2'b01:   cnt_q <= cnt_q - 1'b1;
                  default: cnt_q <= cnt_q;
               endcase
            end
         end
         always_ff @(posedge clk) begin
            if (do_push) mem[wp_q] <= din;
         end
         assign dout  = mem[rp_q];
         assign empty = (cnt_q == '0);
         assign full  = (cnt_q == CNT_W'(DEPTH));
         assign level = cnt_q;
      end
   endgenerate
endmodule

// File: rtl/dcr_chan_group.sv
module dcr_chan_group
   import dcr_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned QDEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_addr,
   input  logic              wr_size,
   input  logic              wr_ctrl,
   input  logic [DATA_W-1:0] wdata,
   input  logic              cmd_pop,
   input  logic              cmd_done,
   output logic              cmd_valid,
   output logic [DATA_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_size,
   output logic [DATA_W-1:0] stg_addr_o,
   output logic [31:0]       ctrl_o,
   output logic              en_o,
   output logic              ovf_o,
   output logic [CPL_W-1:0]  cpl_o
);
   localparam int unsigned ENT_W = 2 * DATA_W;
   localparam int unsigned LVL_W = $clog2(QDEPTH + 1);

   logic [DATA_W-1:0] stg_addr_q;
   logic              stg_v_q;
   logic              en_q;
   logic              ovf_q;
   logic [CPL_W-1:0]  cpl_q;

   logic              q_empty, q_full, q_push, q_pop, q_drop;
   logic [ENT_W-1:0]  q_head;
   logic [LVL_W-1:0]  q_level;

   assign q_push = wr_size && stg_v_q && !q_full;
   assign q_drop = wr_size && stg_v_q && q_full;
   assign q_pop  = cmd_pop && cmd_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_addr_q <= '0;
         stg_v_q    <= 1'b0;
         en_q       <= 1'b0;
         ovf_q      <= 1'b0;
         cpl_q      <= '0;
      end else begin
         if (wr_addr) begin
            stg_addr_q <= wdata;
            stg_v_q    <= 1'b1;
         end else if (wr_size) begin
            stg_v_q    <= 1'b0;
         end
         if (wr_ctrl) en_q <= wdata[CTRL_EN];
         if (q_drop) begin
            ovf_q <= 1'b1;
         end else if (wr_ctrl && wdata[CTRL_OVF]) begin
            ovf_q <= 1'b0;
         end
         if (cmd_done) cpl_q <= cpl_q + 1'b1;
      end
   end

   dcr_cmd_fifo #(
      .WIDTH (ENT_W),
      .DEPTH (QDEPTH)
   ) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push),
      .pop   (q_pop),
      .din   ({stg_addr_q, wdata}),
      .dout  (q_head),
      .empty (q_empty),
      .full  (q_full),
      .level (q_level)
   );

   assign cmd_valid  = en_q && !q_empty;
   assign cmd_addr   = q_head[ENT_W-1:DATA_W];
   assign cmd_size   = q_head[DATA_W-1:0];
   assign stg_addr_o = stg_addr_q;
   assign ctrl_o     = pack_ctrl(en_q, ovf_q, stg_v_q, 8'(q_level));
   assign en_o       = en_q;
   assign ovf_o      = ovf_q;
   assign cpl_o      = cpl_q;
endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile
   import dcr_pkg::*;
#(
   parameter int unsigned NUM_CH     = 6,
   parameter int unsigned QDEPTH     = 4,
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned DATA_W     = 32,
   parameter logic [31:0] CH_KINDS   = 32'h0000_0C6D,
   parameter int unsigned USER_BASE  = 'h800,
   parameter int unsigned USER_WORDS = 'h100,
   localparam int unsigned USER_AW   = $clog2(USER_WORDS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_write,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic                     rsp_valid,
   output logic [DATA_W-1:0]        rsp_rdata,
   output logic                     usr_wr_en,
   output logic                     usr_rd_en,
   output logic [USER_AW-1:0]       usr_addr,
   output logic [DATA_W-1:0]        usr_wdata,
   input  logic [DATA_W-1:0]        usr_rdata,
   output logic [NUM_CH-1:0]        cmd_valid,
   output logic [NUM_CH*DATA_W-1:0] cmd_addr,
   output logic [NUM_CH*DATA_W-1:0] cmd_size,
   input  logic [NUM_CH-1:0]        cmd_pop,
   input  logic [NUM_CH-1:0]        cmd_done
);
   localparam int unsigned NCW = (NUM_CH + CPL_PER_WORD - 1) / CPL_PER_WORD;
   localparam logic [31:0] KIND_MASK = (NUM_CH >= MAX_CH) ? 32'hFFFF_FFFF
                                       : ((32'd1 << (2 * NUM_CH)) - 32'd1);
   localparam logic [31:0] CAP_ID_WORD   = (32'(QDEPTH) << 8) | 32'(NUM_CH);
   localparam logic [31:0] CAP_KIND_WORD = CH_KINDS & KIND_MASK;

   generate
      if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_chk_ch
         $error("dma_chan_regfile: NUM_CH out of range");
      end
      if (DATA_W != 32) begin : g_chk_dw
         $error("dma_chan_regfile: register words are 32 bits");
      end
      if (QDEPTH < 1 || QDEPTH > 255) begin : g_chk_qd
         $error("dma_chan_regfile: QDEPTH must fit the 8-bit level field");
      end
      if (ADDR_W > 32 || (64'd1 << ADDR_W) < 64'(USER_BASE + USER_WORDS)) begin : g_chk_aw
         $error("dma_chan_regfile: user window exceeds address space");
      end
      if (USER_BASE < REG_SPACE_END) begin : g_chk_ub
         $error("dma_chan_regfile: user window overlaps internal registers");
      end
      if (USER_WORDS < 2 || (USER_WORDS & (USER_WORDS - 1)) != 0
          || (USER_BASE % USER_WORDS) != 0) begin : g_chk_uw
         $error("dma_chan_regfile: user window must be an aligned power of two");
      end
   endgenerate

   logic [31:0]       addr_ext;
   logic              host_rd, host_wr, in_user;
   logic [NUM_CH-1:0] wr_addr_v, wr_size_v, wr_ctrl_v;
   logic [NUM_CH-1:0] ch_en, ch_ovf;
   logic [NUM_CH*CPL_W-1:0] cpl_flat;
   logic [NCW*32-1:0] cpl_pad;
   logic [DATA_W-1:0] stg_addr [NUM_CH];
   logic [31:0]       ctrl_rd  [NUM_CH];
   logic [DATA_W-1:0] rd_c;
   logic              rsp_v_q, rsp_user_q;
   logic [DATA_W-1:0] rsp_d_q;

   assign addr_ext = 32'(req_addr);
   assign host_rd  = req_valid && !req_write;
   assign host_wr  = req_valid && req_write;
   assign in_user  = (addr_ext >= 32'(USER_BASE)) && (addr_ext < 32'(USER_BASE + USER_WORDS));

   always_comb begin
      for (int i = 0; i < NUM_CH; i++) begin
         wr_addr_v[i] = host_wr && (addr_ext == 32'(CH_BASE_ADR + CH_STRIDE * i + CH_OFS_ADDR));
         wr_size_v[i] = host_wr && (addr_ext == 32'(CH_BASE_ADR + CH_STRIDE * i + CH_OFS_SIZE));
         wr_ctrl_v[i] = host_wr && (addr_ext == 32'(CH_BASE_ADR + CH_STRIDE * i + CH_OFS_CTRL));
      end
   end

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
         dcr_chan_group #(
            .DATA_W (DATA_W),
            .QDEPTH (QDEPTH)
         ) u_grp (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_addr    (wr_addr_v[g]),
            .wr_size    (wr_size_v[g]),
            .wr_ctrl    (wr_ctrl_v[g]),
            .wdata      (req_wdata),
            .cmd_pop    (cmd_pop[g]),
            .cmd_done   (cmd_done[g]),
            .cmd_valid  (cmd_valid[g]),
            .cmd_addr   (cmd_addr[g*DATA_W +: DATA_W]),
            .cmd_size   (cmd_size[g*DATA_W +: DATA_W]),
            .stg_addr_o (stg_addr[g]),
            .ctrl_o     (ctrl_rd[g]),
            .en_o       (ch_en[g]),
            .ovf_o      (ch_ovf[g]),
            .cpl_o      (cpl_flat[g*CPL_W +: CPL_W])
         );
      end
   endgenerate

   always_comb begin
      cpl_pad = '0;
      cpl_pad[NUM_CH*CPL_W-1:0] = cpl_flat;
   end

   always_comb begin
      rd_c = '0;
      if (addr_ext == 32'(CAP_ID_ADR))   rd_c = CAP_ID_WORD;
      if (addr_ext == 32'(CAP_TYPE_ADR)) rd_c = CAP_KIND_WORD;
      for (int k = 0; k < NCW; k++) begin
         if (addr_ext == 32'(CPL_BASE_ADR + k)) rd_c = cpl_pad[k*32 +: 32];
      end
      for (int i = 0; i < NUM_CH; i++) begin
         if (addr_ext == 32'(CH_BASE_ADR + CH_STRIDE * i + CH_OFS_ADDR)) rd_c = stg_addr[i];
         if (addr_ext == 32'(CH_BASE_ADR + CH_STRIDE * i + CH_OFS_CTRL)) rd_c = ctrl_rd[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_v_q    <= 1'b0;
         rsp_user_q <= 1'b0;
         rsp_d_q    <= '0;
      end else begin
         rsp_v_q    <= host_rd;
         rsp_user_q <= host_rd && in_user;
         rsp_d_q    <= (host_rd && !in_user) ? rd_c : '0;
      end
   end

   assign rsp_valid = rsp_v_q;
   assign rsp_rdata = rsp_user_q ? usr_rdata : rsp_d_q;
   assign usr_wr_en = host_wr && in_user;
   assign usr_rd_en = host_rd && in_user;
   assign usr_addr  = req_addr[USER_AW-1:0];
   assign usr_wdata = req_wdata;
endmodule

// File: rtl/dcr_checker.sv
module dcr_checker
   import dcr_pkg::*;
#(
   parameter int unsigned NUM_CH = 6,
   parameter int unsigned ADDR_W = 12
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid,
   input logic                    req_write,
   input logic [ADDR_W-1:0]       req_addr,
   input logic                    wr_clr_bit,
   input logic                    rsp_valid,
   input logic                    usr_wr_en,
   input logic                    usr_rd_en,
   input logic [NUM_CH-1:0]       cmd_valid,
   input logic [NUM_CH-1:0]       cmd_done,
   input logic [NUM_CH-1:0]       ch_en,
   input logic [NUM_CH-1:0]       ch_ovf,
   input logic [NUM_CH*CPL_W-1:0] cpl_flat
);
   AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write |=> rsp_valid); // R7
   AST_RSP_ONLY_READS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && !req_write)); // R7
   AST_USR_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({usr_wr_en, usr_rd_en})); // R9
   AST_USR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (usr_wr_en || usr_rd_en) |-> req_valid); // R9

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
         AST_CPL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_done[g] |=> cpl_flat[g*CPL_W +: CPL_W] == $past(cpl_flat[g*CPL_W +: CPL_W]) + 8'd1); // R6
         AST_NO_VALID_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[g] |-> !cmd_valid[g]); // R5
         AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            ch_ovf[g] && !(req_valid && req_write && wr_clr_bit
               && 32'(req_addr) == 32'(CH_BASE_ADR + CH_STRIDE * g + CH_OFS_CTRL))
            |=> ch_ovf[g]); // R4
      end
   endgenerate
endmodule

bind dma_chan_regfile dcr_checker #(
   .NUM_CH (NUM_CH),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_addr   (req_addr),
   .wr_clr_bit (req_wdata[1]),
   .rsp_valid  (rsp_valid),
   .usr_wr_en  (usr_wr_en),
   .usr_rd_en  (usr_rd_en),
   .cmd_valid  (cmd_valid),
   .cmd_done   (cmd_done),
   .ch_en      (ch_en),
   .ch_ovf     (ch_ovf),
   .cpl_flat   (cpl_flat)
);

// File: tb/sim_dma_chan_regfile.sv
module sim_dma_chan_regfile;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0, req_write = 1'b0;
   logic [11:0]     req_addr = '0;
   logic [31:0]     req_wdata = '0;
   logic            rsp_valid;
   logic [31:0]     rsp_rdata;
   logic            usr_wr_en, usr_rd_en;
   logic [7:0]      usr_addr;
   logic [31:0]     usr_wdata;
   logic [31:0]     usr_rdata = '0;
   logic [NCH-1:0]  cmd_valid;
   logic [NCH*32-1:0] cmd_addr, cmd_size;
   logic [NCH-1:0]  cmd_pop = '0, cmd_done = '0;

   int checks = 0, failures = 0, cyc = 0;
   int reads_sent = 0, rsp_seen = 0;
   int uw_cnt = 0, ur_cnt = 0;
   logic [7:0]  uw_off = '0;
   logic [31:0] uw_data = '0;
   bit finished = 0;

   typedef struct { logic [31:0] exp; int due; string tag; } exp_t;
   exp_t sb[$];

   dma_chan_regfile u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .usr_wr_en(usr_wr_en), .usr_rd_en(usr_rd_en),
      .usr_addr(usr_addr), .usr_wdata(usr_wdata), .usr_rdata(usr_rdata),
      .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_size(cmd_size),
      .cmd_pop(cmd_pop), .cmd_done(cmd_done));

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // user register model: answers one cycle after the read strobe
   always @(posedge clk) usr_rdata <= usr_rd_en ? (32'hC0DE_0000 | 32'(usr_addr)) : 32'h0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard when responses appear
   always @(negedge clk) begin
      exp_t e;
      if (rst_n) begin
         if (usr_wr_en) begin uw_cnt++; uw_off = usr_addr; uw_data = usr_wdata; end
         if (usr_rd_en) ur_cnt++;
         if (rsp_valid) begin
            rsp_seen++;
            if (sb.size() == 0) begin
               chk("R7 unexpected response", 32'(rsp_valid), 32'h0);
            end else begin
               e = sb.pop_front();
               chk({e.tag, " (R7 latency)"}, 32'(cyc), 32'(e.due));
               chk(e.tag, rsp_rdata, e.exp);
            end
         end else if (sb.size() > 0 && sb[0].due <= cyc) begin
            e = sb.pop_front();
            chk({e.tag, " R7 missing response"}, 32'(rsp_valid), 32'h1);
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(posedge clk); #1;
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      exp_t e;
      @(posedge clk); #1;
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      e.exp = exp; e.due = cyc + 1; e.tag = tag;
      sb.push_back(e);
      reads_sent++;
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic pop(input int ch);
      @(posedge clk); #1; cmd_pop[ch] = 1'b1;
      @(posedge clk); #1; cmd_pop[ch] = 1'b0;
   endtask

   task automatic done(input int ch, input int n);
      @(posedge clk); #1; cmd_done[ch] = 1'b1;
      repeat (n) @(posedge clk);
      #1; cmd_done[ch] = 1'b0;
   endtask

   function automatic logic [31:0] caddr(input int ch); return cmd_addr[ch*32 +: 32]; endfunction
   function automatic logic [31:0] csize(input int ch); return cmd_size[ch*32 +: 32]; endfunction

   task automatic summary;
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R10 reset state
      chk("R10 cmd_valid after reset", 32'(cmd_valid), 32'h0);
      rd(12'd66, 32'h0, "R10 ctrl ch0 reset");
      rd(12'd16, 32'h0, "R10 completion word reset");
      // R1 capabilities
      rd(12'd0, 32'h0000_0406, "R1 count/depth word");
      rd(12'd1, 32'h0000_0C6D, "R1 kind word");
      wr(12'd0, 32'hFFFF_FFFF);
      chk("R7 no response to write", 32'(rsp_valid), 32'h0);
      rd(12'd0, 32'h0000_0406, "R1 write ignored");
      // R8 unmapped
      rd(12'd5, 32'h0, "R8 gap word");
      rd(12'd67, 32'h0, "R8 spare channel word");
      rd(12'd88, 32'h0, "R8 beyond last channel");
      rd(12'h7FF, 32'h0, "R8 below user window");
      wr(12'd88, 32'h1);
      rd(12'd88, 32'h0, "R8 unmapped write");
      rd(12'd86, 32'h0, "R8 ch5 ctrl untouched");
      // R2/R5 basic queue
      wr(12'd64, 32'h1000); wr(12'd65, 32'h40);
      chk("R5 disabled hides command", 32'(cmd_valid[0]), 32'h0);
      rd(12'd66, 32'h0000_0100, "R5 level 1 disabled");
      wr(12'd66, 32'h1);
      chk("R2 valid when enabled", 32'(cmd_valid[0]), 32'h1);
      chk("R2 head address", caddr(0), 32'h1000);
      chk("R2 head size", csize(0), 32'h40);
      wr(12'd64, 32'h2000); wr(12'd65, 32'h80);
      rd(12'd66, 32'h0000_0201, "R5 level 2");
      pop(0);
      chk("R2 second address", caddr(0), 32'h2000);
      chk("R2 second size", csize(0), 32'h80);
      pop(0);
      chk("R2 empty after pops", 32'(cmd_valid[0]), 32'h0);
      // R3 size without staged address
      wr(12'd65, 32'h99);
      rd(12'd66, 32'h0000_0001, "R3 unstaged size ignored");
      chk("R3 no command", 32'(cmd_valid[0]), 32'h0);
      wr(12'd64, 32'h3000);
      rd(12'd66, 32'h0000_0005, "R5 staged bit");
      rd(12'd64, 32'h3000, "R5 staged address readback");
      rd(12'd65, 32'h0, "R5 size reads zero");
      wr(12'd65, 32'h10);
      rd(12'd66, 32'h0000_0101, "R2 staged pair enqueued");
      wr(12'd66, 32'h0);
      chk("R5 disable gates valid", 32'(cmd_valid[0]), 32'h0);
      pop(0);
      wr(12'd66, 32'h1);
      chk("R5 pop while disabled ignored", caddr(0), 32'h3000);
      chk("R5 valid again", 32'(cmd_valid[0]), 32'h1);
      pop(0);
      // R4 overflow on ch1
      wr(12'd70, 32'h1);
      for (int k = 0; k < 4; k++) begin
         wr(12'd68, 32'hA000 + 32'(k));
         wr(12'd69, 32'(k + 1));
      end
      rd(12'd70, 32'h0000_0401, "R4 queue full");
      wr(12'd68, 32'hB000); wr(12'd69, 32'h55);
      rd(12'd70, 32'h0000_0403, "R4 overflow set");
      chk("R4 head kept", caddr(1), 32'hA000);
      chk("R4 head size kept", csize(1), 32'h1);
      wr(12'd70, 32'h1);
      rd(12'd70, 32'h0000_0403, "R4 sticky without clear bit");
      wr(12'd70, 32'h3);
      rd(12'd70, 32'h0000_0401, "R4 cleared by bit 1");
      // R6 completion counters
      done(0, 3); done(3, 2); done(5, 1);
      rd(12'd16, 32'h0200_0003, "R6 word 0 packing");
      rd(12'd17, 32'h0000_0100, "R6 word 1 packing");
      done(2, 255);
      rd(12'd16, 32'h02FF_0003, "R6 count 255");
      done(2, 1);
      rd(12'd16, 32'h0200_0003, "R6 wrap to zero");
      // R9 user window
      wr(12'h805, 32'hDEAD_BEEF);
      chk("R9 user write strobe", 32'(uw_cnt), 32'h1);
      chk("R9 user write offset", 32'(uw_off), 32'h5);
      chk("R9 user write data", uw_data, 32'hDEAD_BEEF);
      rd(12'h8FF, 32'hC0DE_00FF, "R9 top of window");
      rd(12'h800, 32'hC0DE_0000, "R9 base of window");
      rd(12'h900, 32'h0, "R9 above window");
      wr(12'h7FF, 32'h1);
      repeat (3) @(posedge clk);
      #1;
      chk("R9 read strobes in window only", 32'(ur_cnt), 32'h2);
      chk("R9 write strobes in window only", 32'(uw_cnt), 32'h1);
      chk("R7 all reads answered", 32'(rsp_seen), 32'(reads_sent));
      summary();
   end
endmodule